// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of a DMA transfer engine and decides which of its channels the engine should serve next. Each channel has two peripheral request lines, one for single transfers and one for bursts, plus a software request bit. Per-channel control bitmaps say whether the channel is enabled, whether its peripheral requests are blocked, whether it only answers bursts, and whether it is in the high priority group. The block filters every channel through these bitmaps, then ranks the survivors and picks one.

The choice is registered into a grant that holds a one-hot vector, the matching binary index and a valid flag. A grant is only started while the controller master enable is set and the engine reports idle. Once issued, it stays frozen until the engine acknowledges it or the master enable is withdrawn.

The controller has two states. ARB_IDLE holds no grant. It moves to ARB_GRANT on the clock edge where the master enable is set, the engine is idle and at least one channel qualifies. ARB_GRANT holds the grant. It returns to ARB_IDLE on the edge where the engine acknowledges or the master enable is clear. Otherwise each state stays where it is.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the grant valid flag is 0, the one-hot grant is all zeros and the grant index is 0.
- R2: A channel whose enable bit is 0 is never granted, whatever its requests.
- R3: A channel whose mask bit is 1 ignores both of its peripheral request lines, but its software request bit still gets it granted.
- R4: A channel whose burst-only bit is 1 ignores its single request line and is granted on its burst request line.
- R5: A channel whose burst-only bit is 0 is granted on either its single or its burst request line.
- R6: A software request bit qualifies its channel whatever that channel's burst-only bit is.
- R7: Any qualifying channel with its priority bit at 1 wins over every qualifying channel whose priority bit is 0, regardless of channel number.
- R8: Among qualifying channels of the same priority level, the lowest-numbered channel wins.
- R9: No grant starts while master enable is 0. A held grant is dropped on the first clock edge at which master enable is 0.
- R10: A grant starts only on a clock edge at which the engine idle input is 1. It is visible right after that edge.
- R11: A held grant keeps the same channel, even if requests change, until the engine acknowledge is seen at an edge. The grant is cleared right after that edge. While valid, the one-hot vector has exactly one bit set, at bit position grant_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Controller master enable |
| engine_idle | input | 1 | Transfer engine ready for a new channel |
| engine_ack | input | 1 | Engine has taken the current grant |
| single_req | input | 32 | Peripheral single requests, bit n for channel n |
| burst_req | input | 32 | Peripheral burst requests, bit n for channel n |
| sw_req | input | 32 | Software requests, bit n for channel n |
| chan_en | input | 32 | Channel enable bitmap |
| req_mask | input | 32 | Peripheral request block bitmap |
| burst_only | input | 32 | Burst-only bitmap |
| hi_prio | input | 32 | High priority bitmap |
| grant_valid | output | 1 | A grant is held |
| grant_onehot | output | 32 | One-hot granted channel |
| grant_idx | output | 5 | Binary granted channel number |

## Verification
Every result of this block is due on the first rising edge after its stimulus settles. A new grant, a grant dropped on acknowledge and a grant dropped when master enable falls all appear after exactly one register stage. The driver applies inputs on a falling edge and waits for the next rising edge. It then pushes the expected grant into the scoreboard queue. The monitor pops that entry on the following falling edge, half a period after the registers updated, and compares the valid flag, index and one-hot vector.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dmaarb_qualify.sv
module dmaarb_qualify #(
    parameter int N_CH = 32
) (
    input  logic [N_CH-1:0] single_req,
    input  logic [N_CH-1:0] burst_req,
    input  logic [N_CH-1:0] sw_req,
    input  logic [N_CH-1:0] chan_en,
    input  logic [N_CH-1:0] req_mask,
    input  logic [N_CH-1:0] burst_only,
    output logic [N_CH-1:0] qualified
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic periph_hit;
        // single requests count only when the channel is not burst-only (R4, R5)
        assign periph_hit = burst_req[c] | (single_req[c] & ~burst_only[c]);
        // mask blocks peripheral lines only; software bypasses it (R3, R6)
        assign qualified[c] = chan_en[c] & (sw_req[c] | (periph_hit & ~req_mask[c]));
    end

endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
    parameter int N_CH = 32,
    parameter int IW   = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] req,
    output logic            any,
    output logic [IW-1:0]   idx,
    output logic [N_CH-1:0] onehot
);

    always_comb begin
        idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any    = |req;
        onehot = '0;
        if (any) onehot[idx] = 1'b1;
    end

    // R8: the picked bit is a requesting one and no lower bit requests
    always_comb begin
        a_pick_subset_r8: assert ((onehot & ~req) == '0);
        a_pick_lowest_r8: assert (((onehot - 1'b1) & req & {N_CH{any}}) == '0);
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dmaarb_pkg::*;
#(
    parameter int N_CH = 32,
    localparam int IW  = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_en,
    input  logic            engine_idle,
    input  logic            engine_ack,
    input  logic [N_CH-1:0] single_req,
    input  logic [N_CH-1:0] burst_req,
    input  logic [N_CH-1:0] sw_req,
    input  logic [N_CH-1:0] chan_en,
    input  logic [N_CH-1:0] req_mask,
    input  logic [N_CH-1:0] burst_only,
    input  logic [N_CH-1:0] hi_prio,
    output logic            grant_valid,
    output logic [N_CH-1:0] grant_onehot,
    output logic [IW-1:0]   grant_idx
);

    arb_state_e      state_q, state_d;
    logic [N_CH-1:0] qual, qual_hi, ranked;
    logic            pick_any;
    logic [IW-1:0]   pick_idx;
    logic [N_CH-1:0] pick_oh;

    dmaarb_qualify #(.N_CH(N_CH)) u_qual (
        .single_req (single_req),
        .burst_req  (burst_req),
        .sw_req     (sw_req),
        .chan_en    (chan_en),
        .req_mask   (req_mask),
        .burst_only (burst_only),
        .qualified  (qual)
    );

    // R7: the high group, if non-empty, hides every default channel
    assign qual_hi = qual & hi_prio;
    assign ranked  = (|qual_hi) ? qual_hi : qual;

    dmaarb_pick #(.N_CH(N_CH), .IW(IW)) u_pick (
        .req    (ranked),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (master_en && engine_idle && pick_any) state_d = ARB_GRANT;
            ARB_GRANT: if (!master_en || engine_ack)             state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_onehot <= '0;
            grant_idx    <= '0;
        end else if (state_q == ARB_IDLE && state_d == ARB_GRANT) begin
            grant_onehot <= pick_oh;
            grant_idx    <= pick_idx;
        end else if (state_d == ARB_IDLE) begin
            grant_onehot <= '0;
            grant_idx    <= '0;
        end
    end

    assign grant_valid = (state_q == ARB_GRANT);

    // R9: master enable low at an edge leaves no grant after it
    p_off_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !grant_valid);

    // R10: a new grant follows an edge at which the engine was idle
    p_start_on_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(engine_idle));

    // R2: a freshly granted channel was enabled at the deciding edge
    p_grant_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (($past(chan_en) & grant_onehot) != '0));

    // R11: held grant is frozen until acknowledge
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !engine_ack && master_en) |=> (grant_valid && $stable(grant_idx)));

    // R11: exactly one bit while valid, none while idle
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid ? ($countones(grant_onehot) == 1) : (grant_onehot == '0));

    // R11: acknowledge ends the grant at the next edge
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && engine_ack) |=> !grant_valid);

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;

    localparam int N  = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_en = 1'b0, engine_idle = 1'b1, engine_ack = 1'b0;
    logic [N-1:0]  single_req = '0, burst_req = '0, sw_req = '0;
    logic [N-1:0]  chan_en = '0, req_mask = '0, burst_only = '0, hi_prio = '0;
    logic          grant_valid;
    logic [N-1:0]  grant_onehot;
    logic [IW-1:0] grant_idx;

    always #4 clk = ~clk;  // 125 MHz

    dma_req_arbiter uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .engine_idle(engine_idle), .engine_ack(engine_ack),
        .single_req(single_req), .burst_req(burst_req), .sw_req(sw_req),
        .chan_en(chan_en), .req_mask(req_mask), .burst_only(burst_only),
        .hi_prio(hi_prio), .grant_valid(grant_valid),
        .grant_onehot(grant_onehot), .grant_idx(grant_idx)
    );

    int  exp_v_q[$];
    int  exp_i_q[$];
    int  exp_r_q[$];
    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // driver side: one rising edge, then queue the expectation
    task automatic expect_after_edge(input int v, input int idx, input int req);
        @(posedge clk);
        exp_v_q.push_back(v);
        exp_i_q.push_back(idx);
        exp_r_q.push_back(req);
    endtask

    task automatic at_fall();
        @(negedge clk);
    endtask

    task automatic clear_all();
        single_req = '0; burst_req = '0; sw_req = '0;
        chan_en = '0; req_mask = '0; burst_only = '0; hi_prio = '0;
    endtask

    // acknowledge the held grant; R11: cleared after the ack edge
    task automatic release_grant();
        at_fall();
        engine_ack = 1'b1;
        expect_after_edge(0, 0, 11);
        at_fall();
        engine_ack = 1'b0;
        clear_all();
    endtask

    // monitor: compare half a period after each edge
    always @(negedge clk) begin
        if (exp_v_q.size() > 0) begin
            int v, idx, req;
            logic [N-1:0] oh;
            v   = exp_v_q.pop_front();
            idx = exp_i_q.pop_front();
            req = exp_r_q.pop_front();
            oh  = (v != 0) ? (N'(1) << idx) : '0;
            n_cmp++;
            if (grant_valid !== (v != 0) || grant_idx !== IW'(idx) || grant_onehot !== oh) begin
                n_bad++;
                $display("FAIL R%0d: valid=%0b idx=%0d onehot=%h expected valid=%0d idx=%0d onehot=%h",
                         req, grant_valid, grant_idx, grant_onehot, v, idx, oh);
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) at_fall();
        rst_n = 1'b1;

        // R1: reset state with nothing requested
        expect_after_edge(0, 0, 1);

        // R9: master enable low blocks a valid request
        at_fall();
        chan_en[3] = 1'b1; single_req[3] = 1'b1;
        expect_after_edge(0, 0, 9);

        // R5: single request on a normal channel
        at_fall();
        master_en = 1'b1;
        expect_after_edge(1, 3, 5);
        release_grant();

        // R5: burst request on a normal channel
        chan_en[5] = 1'b1; burst_req[5] = 1'b1;
        expect_after_edge(1, 5, 5);
        release_grant();

        // R2: disabled channel 2 loses to enabled channel 7
        single_req[2] = 1'b1; single_req[7] = 1'b1; chan_en[7] = 1'b1;
        expect_after_edge(1, 7, 2);
        release_grant();

        // R3: masked channel ignores both peripheral lines
        chan_en[4] = 1'b1; req_mask[4] = 1'b1; single_req[4] = 1'b1; burst_req[4] = 1'b1;
        expect_after_edge(0, 0, 3);
        at_fall();
        sw_req[4] = 1'b1;  // R3: software still starts it
        expect_after_edge(1, 4, 3);
        release_grant();

        // R4: burst-only channel ignores single, answers burst
        chan_en[6] = 1'b1; burst_only[6] = 1'b1; single_req[6] = 1'b1;
        expect_after_edge(0, 0, 4);
        at_fall();
        burst_req[6] = 1'b1;
        expect_after_edge(1, 6, 4);
        release_grant();

        // R6: software request on a burst-only channel
        chan_en[9] = 1'b1; burst_only[9] = 1'b1; sw_req[9] = 1'b1;
        expect_after_edge(1, 9, 6);
        release_grant();

        // R8: lowest number wins within the default level
        chan_en = '1;
        single_req[10] = 1'b1; single_req[20] = 1'b1; single_req[31] = 1'b1;
        expect_after_edge(1, 10, 8);
        release_grant();

        // R7: a high priority channel beats a lower-numbered default one
        chan_en = '1;
        single_req[10] = 1'b1; single_req[31] = 1'b1; hi_prio[31] = 1'b1;
        expect_after_edge(1, 31, 7);
        release_grant();

        // R8: two high priority channels, lowest of them wins
        chan_en = '1;
        single_req[1] = 1'b1; burst_req[20] = 1'b1; sw_req[31] = 1'b1;
        hi_prio[20] = 1'b1; hi_prio[31] = 1'b1;
        expect_after_edge(1, 20, 8);
        release_grant();

        // R10: busy engine delays the grant
        engine_idle = 1'b0;
        chan_en[12] = 1'b1; single_req[12] = 1'b1;
        expect_after_edge(0, 0, 10);
        at_fall();
        engine_idle = 1'b1;
        expect_after_edge(1, 12, 10);

        // R11: a stronger request arriving during the hold changes nothing
        at_fall();
        chan_en[0] = 1'b1; sw_req[0] = 1'b1; hi_prio[0] = 1'b1;
        expect_after_edge(1, 12, 11);
        at_fall();
        expect_after_edge(1, 12, 11);
        release_grant();

        // R9: dropping master enable withdraws a held grant
        chan_en[15] = 1'b1; burst_req[15] = 1'b1;
        expect_after_edge(1, 15, 9);
        at_fall();
        master_en = 1'b0;
        expect_after_edge(0, 0, 9);
        at_fall();
        expect_after_edge(0, 0, 9);

        repeat (2) at_fall();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule